// File: doc/BRIEF.md
# Slot-Scheduled Burst Transmit Sequencer

This block sends host-supplied bursts to a modulator at a chosen time slot. The host writes bytes into a 32-entry byte queue. It programs a bit count and a target slot number, then issues a start command. The block waits until the slot timing source signals that slot. It then raises the RF enable and shifts out exactly the programmed number of bits, one on each modulator bit tick, taking the most significant bit of each byte first.

When a message finishes and the queue still holds data, the block treats that data as a chained follow-on message. It keeps RF enabled and begins the next message at the following slot boundary. When a message finishes and the queue is empty, it ramps down, drops RF and signals completion.

If the carrier-sense option is on and a carrier is present at the scheduled slot, the burst is aborted and the queued data is kept. Queue underrun and overrun are reported through sticky flags and an error interrupt, and transmission carries on. A control write can reset the sequencer, clear the queue, or do both.

Top module: `burst_tx_sequencer`

## Requirements
- R1: After reset the state output is Idle (code 0), rf_en is low, both sticky flags are low, bit_valid is low and the queue level is 0.
- R2: A start command in Idle (0) or Aborted (4), with no ramp in progress, latches cfg_slot and cfg_bits and moves the state to Pending (code 1). A start command in any other state is ignored, and the slot latched earlier still applies.
- R3: The queue holds 32 bytes. A write while it is full is dropped, the level stays at 32, the sticky overflow flag is set and irq_fifo_err pulses for one cycle.
- R4: In Pending, only a slot strobe whose slot_num equals the latched slot moves the state to In progress (code 2). rf_en rises on that same clock edge and stays high throughout In progress and Chained.
- R5: While In progress, each bit_tick produces one bit_out with a one-cycle bit_valid, taken from each byte starting at bit 7. Exactly the latched count of bits is sent, and the unsent low bits of a partly used last byte are discarded.
- R6: When a message ends and the queue is empty, the state becomes Idle and irq_done pulses for one cycle. ramp_busy is then high for 4 cycles, and rf_en falls on the fourth clock edge after the end.
- R7: When a message ends and the queue is not empty, the state becomes Chained (code 3) and cfg_bits is latched as the new count. rf_en stays high and irq_done does not pulse. The next slot strobe, with any slot number, returns the state to In progress.
- R8: With cs_enable high, a carrier_det at the matching slot strobe moves the state to Aborted (code 4) and pulses irq_done. rf_en stays low and the queue level is unchanged.
- R9: If a byte is needed while the queue is empty, the bits of that byte are sent as zeros and still count toward the total. The sticky underflow flag is set, irq_fifo_err pulses, and the message completes normally.
- R10: A stat_rd pulse clears both sticky flags, unless a new event sets a flag in the same cycle.
- R11: The reset command makes the state Idle at once and stops bit output without pulsing irq_done. If rf_en was high, it falls after the 4-cycle ramp. The clear command empties the queue, and both commands may be given in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| ctl_we | input | 1 | Control write strobe |
| ctl_start | input | 1 | Start request (with ctl_we) |
| ctl_sreset | input | 1 | Sequencer reset (with ctl_we) |
| ctl_fclear | input | 1 | Queue clear (with ctl_we) |
| cfg_slot | input | SLOT_W | Target slot number |
| cfg_bits | input | BITS_W | Message length in bits |
| cs_enable | input | 1 | Carrier-sense abort enable |
| carrier_det | input | 1 | Carrier present |
| slot_strobe | input | 1 | Slot boundary pulse |
| slot_num | input | SLOT_W | Number of the slot starting |
| bit_tick | input | 1 | Modulator requests a bit |
| stat_rd | input | 1 | Status read; clears sticky flags |
| tx_state | output | 3 | 0 Idle, 1 Pending, 2 In progress, 3 Chained, 4 Aborted |
| flag_underflow | output | 1 | Sticky queue underflow |
| flag_overflow | output | 1 | Sticky queue overflow |
| irq_done | output | 1 | One-cycle completion/abort interrupt |
| irq_fifo_err | output | 1 | One-cycle queue error interrupt |
| bit_out | output | 1 | Serial data bit |
| bit_valid | output | 1 | bit_out holds a new bit |
| rf_en | output | 1 | RF circuit enable |
| ramp_busy | output | 1 | Ramp-down in progress |
| fifo_level | output | 6 | Bytes held in the queue |

## Verification
The bench builds the block with its default values: a 32-byte queue, 12-bit counts and slot numbers, and a 4-cycle ramp. With a 32-byte queue, 33 writes are enough to reach overflow. A 4-cycle ramp lets the fall of rf_en be checked on an exact edge. The 12-bit count allows lengths that are not whole bytes, such as 12 and 10, so discarding the last byte's padding is observable. Holding bit_tick high sends a bit every cycle, which puts the end-of-message decision and chaining within a few dozen cycles.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PEND  = 3'd1,
    ST_SEND  = 3'd2,
    ST_CHAIN = 3'd3,
    ST_ABORT = 3'd4
  } tx_state_e;
endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [AW:0]   level,
  output logic          ovf_evt
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic wr_ok, rd_ok;

  assign empty   = (level == '0);
  assign full    = (level == (AW+1)'(DEPTH));
  assign wr_ok   = wr && !full && !clr;
  assign rd_ok   = rd && !empty && !clr;
  assign ovf_evt = wr && full && !clr;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp <= '0;
      rp <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // A write into a full queue must leave the level untouched.
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (full && wr && !rd && !clr) |=> (level == (AW+1)'(DEPTH)));
endmodule

// File: rtl/tx_bit_shifter.sv
module tx_bit_shifter #(
  parameter int BITS_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [BITS_W-1:0] load_bits,
  input  logic              tick,
  input  logic              fifo_empty,
  input  logic [7:0]        fifo_data,
  output logic              pop,
  output logic              udf_evt,
  output logic              bit_out,
  output logic              bit_valid,
  output logic              busy
);
  logic [BITS_W-1:0] left;
  logic [2:0] pos;
  logic [7:0] sh;
  logic step, need;
  logic [7:0] cur;

  assign step    = tick && (left != '0) && !clr && !load;
  assign need    = step && (pos == 3'd0);
  assign pop     = need && !fifo_empty;
  assign udf_evt = need && fifo_empty;
  assign busy    = (left != '0);
  assign cur     = (pos != 3'd0) ? sh : (fifo_empty ? 8'h00 : fifo_data);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      left <= '0;
      pos <= '0;
      sh <= '0;
      bit_out <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= step;
      if (load) begin
        left <= load_bits;
        pos <= '0;
      end else if (step) begin
        bit_out <= cur[7];
        sh <= {cur[6:0], 1'b0};
        pos <= pos + 3'd1;
        left <= left - 1'b1;
      end
    end
  end

  assert_valid_follows_tick_R5: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> $past(tick));
  assert_underflow_sends_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (need && fifo_empty) |=> (bit_valid && !bit_out));
endmodule

// File: rtl/tx_ramp_timer.sv
module tx_ramp_timer #(
  parameter int CYC = 4,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (start) cnt <= CW'(CYC);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assert_ramp_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !busy);
endmodule

// File: rtl/burst_tx_sequencer.sv
module burst_tx_sequencer #(
  parameter int FIFO_DEPTH = 32,
  parameter int BITS_W     = 12,
  parameter int SLOT_W     = 12,
  parameter int RAMP_CYC   = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              ctl_we,
  input  logic              ctl_start,
  input  logic              ctl_sreset,
  input  logic              ctl_fclear,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [BITS_W-1:0] cfg_bits,
  input  logic              cs_enable,
  input  logic              carrier_det,
  input  logic              slot_strobe,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic              bit_tick,
  input  logic              stat_rd,
  output logic [2:0]        tx_state,
  output logic              flag_underflow,
  output logic              flag_overflow,
  output logic              irq_done,
  output logic              irq_fifo_err,
  output logic              bit_out,
  output logic              bit_valid,
  output logic              rf_en,
  output logic              ramp_busy,
  output logic [LVL_W-1:0]  fifo_level
);
  import tx_seq_pkg::*;

  tx_state_e         state_q;
  logic [SLOT_W-1:0] lat_slot;
  logic [BITS_W-1:0] lat_bits;
  logic cmd_rst, cmd_clr, cmd_start, slot_hit, cs_abort;
  logic sh_load, sh_tick, sh_busy, sh_pop, udf_evt, ovf_evt;
  logic fifo_empty, fifo_full;
  logic [7:0] fifo_rdata;
  logic msg_end, ramp_start, ramp_done;

  assign cmd_rst   = ctl_we && ctl_sreset;
  assign cmd_clr   = ctl_we && ctl_fclear;
  assign cmd_start = ctl_we && ctl_start;
  assign slot_hit  = slot_strobe && (slot_num == lat_slot);
  assign cs_abort  = cs_enable && carrier_det;
  assign msg_end   = (state_q == ST_SEND) && !sh_busy;
  assign sh_tick   = bit_tick && (state_q == ST_SEND);
  assign sh_load   = !cmd_rst &&
                     (((state_q == ST_PEND) && slot_hit && !cs_abort) ||
                      ((state_q == ST_CHAIN) && slot_strobe));
  assign ramp_start = (!cmd_rst && msg_end && fifo_empty) ||
                      (cmd_rst && rf_en && !ramp_busy);
  assign tx_state  = state_q;

  tx_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst(rst), .clr(cmd_clr), .wr(wr_en), .wdata(wr_data),
    .rd(sh_pop), .rdata(fifo_rdata), .empty(fifo_empty), .full(fifo_full),
    .level(fifo_level), .ovf_evt(ovf_evt)
  );

  tx_bit_shifter #(.BITS_W(BITS_W)) u_shift (
    .clk(clk), .rst(rst), .clr(cmd_rst), .load(sh_load), .load_bits(lat_bits),
    .tick(sh_tick), .fifo_empty(fifo_empty), .fifo_data(fifo_rdata),
    .pop(sh_pop), .udf_evt(udf_evt), .bit_out(bit_out), .bit_valid(bit_valid),
    .busy(sh_busy)
  );

  tx_ramp_timer #(.CYC(RAMP_CYC)) u_ramp (
    .clk(clk), .rst(rst), .start(ramp_start), .busy(ramp_busy), .done(ramp_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      lat_slot <= '0;
      lat_bits <= '0;
      rf_en <= 1'b0;
      irq_done <= 1'b0;
      irq_fifo_err <= 1'b0;
      flag_underflow <= 1'b0;
      flag_overflow <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      irq_fifo_err <= udf_evt || ovf_evt;
      flag_underflow <= udf_evt || (flag_underflow && !stat_rd);
      flag_overflow  <= ovf_evt || (flag_overflow && !stat_rd);
      if (ramp_done) rf_en <= 1'b0;
      if (cmd_rst) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE, ST_ABORT: begin
            if (cmd_start && !ramp_busy) begin
              lat_slot <= cfg_slot;
              lat_bits <= cfg_bits;
              state_q <= ST_PEND;
            end
          end
          ST_PEND: begin
            if (slot_hit) begin
              if (cs_abort) begin
                state_q <= ST_ABORT;
                irq_done <= 1'b1;
              end else begin
                state_q <= ST_SEND;
                rf_en <= 1'b1;
              end
            end
          end
          ST_SEND: begin
            if (msg_end) begin
              if (!fifo_empty) begin
                state_q <= ST_CHAIN;
                lat_bits <= cfg_bits;
              end else begin
                state_q <= ST_IDLE;
                irq_done <= 1'b1;
              end
            end
          end
          ST_CHAIN: begin
            if (slot_strobe) state_q <= ST_SEND;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_rf_held_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEND || state_q == ST_CHAIN) |-> rf_en);
  assert_launch_on_slot_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEND && $past(state_q) == ST_PEND) |->
      $past(slot_strobe && (slot_num == lat_slot)));
  assert_abort_rf_off_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ABORT) |-> !rf_en);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done);
endmodule

// File: tb/sim_burst_tx_sequencer.sv
module sim_burst_tx_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, ctl_we = 0, ctl_start = 0, ctl_sreset = 0, ctl_fclear = 0;
  logic [7:0] wr_data = 0;
  logic [11:0] cfg_slot = 0, slot_num = 0;
  logic [11:0] cfg_bits = 0;
  logic cs_enable = 0, carrier_det = 0, slot_strobe = 0, bit_tick = 1, stat_rd = 0;
  logic [2:0] tx_state;
  logic flag_underflow, flag_overflow, irq_done, irq_fifo_err;
  logic bit_out, bit_valid, rf_en, ramp_busy;
  logic [5:0] fifo_level;

  int errors = 0, total = 0;
  int nb = 0, n_done = 0, n_err = 0;
  logic bits [512];

  always #4 clk = ~clk;

  burst_tx_sequencer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ctl_we(ctl_we),
    .ctl_start(ctl_start), .ctl_sreset(ctl_sreset), .ctl_fclear(ctl_fclear),
    .cfg_slot(cfg_slot), .cfg_bits(cfg_bits), .cs_enable(cs_enable),
    .carrier_det(carrier_det), .slot_strobe(slot_strobe), .slot_num(slot_num),
    .bit_tick(bit_tick), .stat_rd(stat_rd), .tx_state(tx_state),
    .flag_underflow(flag_underflow), .flag_overflow(flag_overflow),
    .irq_done(irq_done), .irq_fifo_err(irq_fifo_err), .bit_out(bit_out),
    .bit_valid(bit_valid), .rf_en(rf_en), .ramp_busy(ramp_busy),
    .fifo_level(fifo_level)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (bit_valid && nb < 512) begin bits[nb] = bit_out; nb = nb + 1; end
      if (irq_done) n_done = n_done + 1;
      if (irq_fifo_err) n_err = n_err + 1;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    wr_en = 1; wr_data = b; step(); wr_en = 0;
  endtask

  task automatic ctl(logic s, logic r, logic c);
    ctl_we = 1; ctl_start = s; ctl_sreset = r; ctl_fclear = c;
    step();
    ctl_we = 0; ctl_start = 0; ctl_sreset = 0; ctl_fclear = 0;
    step();
  endtask

  task automatic strobe(int n);
    slot_strobe = 1; slot_num = 12'(n); step();
    slot_strobe = 0; step();
  endtask

  task automatic wait_leave(int st, string tag);
    for (int i = 0; i < 400; i++) begin
      if (tx_state != 3'(st)) return;
      step();
    end
    check(tag, int'(tx_state), 99);
  endtask

  task automatic wait_ramp();
    for (int i = 0; i < 20 && ramp_busy; i++) step();
  endtask

  // Compare n received bits from offset with the MSB-first bits of {b0,b1}.
  task automatic chk_bits(string tag, int off, int n, logic [15:0] word);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (bits[off + i] !== word[15 - i]) bad++;
    check(tag, bad, 0);
  endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0; step();
    check("R1 state", int'(tx_state), 0);
    check("R1 rf_en", int'(rf_en), 0);
    check("R1 flags", int'({flag_underflow, flag_overflow}), 0);
    check("R1 valid", int'(bit_valid), 0);
    check("R1 level", int'(fifo_level), 0);
  endtask

  task automatic t_basic();
    int d0;
    push(8'hA5); push(8'h3C);
    cfg_bits = 12; cfg_slot = 5;
    ctl(1, 0, 0);
    check("R2 pending", int'(tx_state), 1);
    cfg_slot = 6; ctl(1, 0, 0);
    strobe(4);
    check("R4 wrong slot", int'(tx_state), 1);
    check("R4 rf off", int'(rf_en), 0);
    nb = 0; d0 = n_done;
    slot_strobe = 1; slot_num = 5; step(); slot_strobe = 0;
    check("R2 R4 launch", int'(tx_state), 2);
    check("R4 rf on", int'(rf_en), 1);
    wait_leave(2, "R5 stuck sending");
    check("R6 idle", int'(tx_state), 0);
    check("R6 done irq", n_done - d0, 1);
    check("R5 bit count", nb, 12);
    chk_bits("R5 msb first", 0, 12, 16'hA53C);
    check("R6 ramp busy", int'(ramp_busy), 1);
    step(); step(); step();
    check("R6 rf during ramp", int'(rf_en), 1);
    step();
    check("R6 rf dropped", int'(rf_en), 0);
    check("R6 ramp over", int'(ramp_busy), 0);
  endtask

  task automatic t_chain();
    int d0;
    push(8'hF0); push(8'h81); push(8'h40);
    cfg_bits = 8; cfg_slot = 20;
    ctl(1, 0, 0);
    cfg_bits = 10;
    nb = 0; d0 = n_done;
    strobe(20);
    wait_leave(2, "R7 stuck first");
    check("R7 chained", int'(tx_state), 3);
    check("R7 rf kept", int'(rf_en), 1);
    check("R7 no irq", n_done - d0, 0);
    check("R7 first len", nb, 8);
    chk_bits("R7 first bits", 0, 8, 16'hF000);
    strobe(7);
    check("R7 resume", int'(tx_state) == 2 || nb > 8 ? 1 : 0, 1);
    wait_leave(2, "R7 stuck second");
    check("R7 end idle", int'(tx_state), 0);
    check("R7 total len", nb, 18);
    chk_bits("R7 second bits", 8, 10, 16'h8140);
    check("R7 done irq", n_done - d0, 1);
    wait_ramp();
  endtask

  task automatic t_abort();
    int d0;
    push(8'h55);
    cs_enable = 1; carrier_det = 1; cfg_slot = 9; cfg_bits = 8;
    ctl(1, 0, 0);
    d0 = n_done; nb = 0;
    strobe(9);
    check("R8 aborted", int'(tx_state), 4);
    check("R8 done irq", n_done - d0, 1);
    check("R8 rf off", int'(rf_en), 0);
    check("R8 fifo kept", int'(fifo_level), 1);
    check("R8 no bits", nb, 0);
    cs_enable = 0; carrier_det = 0;
    ctl(0, 1, 1);
    check("R11 reset+clear state", int'(tx_state), 0);
    check("R11 reset+clear level", int'(fifo_level), 0);
  endtask

  task automatic t_underflow();
    int e0;
    push(8'hFF);
    cfg_bits = 12; cfg_slot = 3;
    ctl(1, 0, 0);
    nb = 0; e0 = n_err;
    strobe(3);
    wait_leave(2, "R9 stuck");
    check("R9 completes", int'(tx_state), 0);
    check("R9 len", nb, 12);
    chk_bits("R9 zero fill", 0, 12, 16'hFF00);
    check("R9 flag", int'(flag_underflow), 1);
    check("R9 err irq", n_err - e0, 1);
    stat_rd = 1; step(); stat_rd = 0;
    check("R10 cleared", int'(flag_underflow), 0);
    wait_ramp();
  endtask

  task automatic t_overflow();
    int e0 = n_err;
    for (int i = 0; i < 33; i++) push(8'(i));
    check("R3 level full", int'(fifo_level), 32);
    check("R3 flag", int'(flag_overflow), 1);
    check("R3 err irq", n_err - e0, 1);
    stat_rd = 1; step(); stat_rd = 0;
    check("R10 ovf cleared", int'(flag_overflow), 0);
    ctl(0, 0, 1);
    check("R11 clear", int'(fifo_level), 0);
  endtask

  task automatic t_sreset();
    int d0, n0;
    push(8'hC3); push(8'h3C);
    cfg_bits = 16; cfg_slot = 11;
    ctl(1, 0, 0);
    d0 = n_done;
    strobe(11);
    step(); step();
    ctl_we = 1; ctl_sreset = 1; step(); ctl_we = 0; ctl_sreset = 0;
    check("R11 idle now", int'(tx_state), 0);
    check("R11 rf ramping", int'(rf_en), 1);
    n0 = nb;
    repeat (5) step();
    check("R11 bits stopped", nb, n0);
    check("R11 rf off", int'(rf_en), 0);
    check("R11 no done", n_done - d0, 0);
    ctl(0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_chain();
    t_abort();
    t_underflow();
    t_overflow();
    t_sreset();
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule